// File: doc/BRIEF.md
# Chip-Select Qualified Bus-Cycle Logger

This block watches a memory chip-select, together with a 32-bit address bus, a 32-bit data bus and two active-low byte write enables. Each time the chip-select goes from low to high, it captures the cycle that just ended. It sorts the cycle into one of six record kinds and stores a timestamped record in a small first-in first-out buffer. Software produces these cycles on purpose: it writes branch targets, logged fetch addresses and process space identifiers into the chip-select window. The buffer then holds a compact execution trace instead of raw bus samples.

The most recent space identifier written by software is kept in the block. It is attached to later kernel and user fetch records, so that logical addresses in those records can be matched to the process that owned them. A free-running cycle counter provides the timestamp. A sticky overflow flag shows that at least one record was lost because the buffer was full. A consumer reads the head record and removes it by pulsing `pop_i`.

Top module: `bus_cycle_logger`

## Requirements
- R1: A record is created only at a clock edge where `cs_i` is sampled high after being sampled low at the previous edge. Holding `cs_i` high creates no further records. A `cs_i` that is high out of reset creates no record.
- R2: A record's address and data fields equal `addr_i` and `data_i` as sampled at the edge that detects the chip-select rise.
- R3: A cycle with both write enables high (a read) is typed FETCH, code 0, whatever its address.
- R4: A cycle with both write enables low and address bit 30 low is typed FLOW, code 1. This takes priority over the offset decode. A write with only one enable low never becomes FLOW.
- R5: The logging base is 0xFF000000, and addr[31:4] must match it. Within that match, a write to offset 0x0 is typed KFETCH (code 2), offset 0x4 is typed UFETCH (code 3) and offset 0x8 is typed SPACE (code 4). Every other write is typed WRITE, code 5.
- R6: A SPACE record carries data[7:0] as its space ID, and that value becomes the current space ID. KFETCH and UFETCH records carry the current space ID, which is 0 after reset. All other record kinds carry 0.
- R7: The timestamp counter is 0 at the first edge after reset and rises by one on every clock. A record's timestamp is the counter value at its capture edge.
- R8: The buffer holds DEPTH (default 8) records in arrival order. While `rec_valid_o` is high, the outputs show the oldest record, and a `pop_i` at an edge removes it.
- R9: A capture that finds the buffer full is dropped, and `ovf_o` is set. The records already stored are unchanged.
- R10: `ovf_o` stays set until `ovf_clr_i` is sampled high. A drop in the same cycle as a clear leaves it set.
- R11: `pop_i` while the buffer is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, also the timestamp clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_i | input | 1 | Chip-select; its rising edge ends a cycle |
| addr_i | input | 32 | Address bus |
| data_i | input | 32 | Data bus |
| wen_n_i | input | 2 | Byte write enables, active low |
| pop_i | input | 1 | Remove the head record |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| rec_valid_o | output | 1 | Buffer is not empty |
| rec_type_o | output | 3 | Head record kind |
| rec_addr_o | output | 32 | Head record address |
| rec_data_o | output | 32 | Head record data word |
| rec_sid_o | output | 8 | Head record space ID |
| rec_ts_o | output | 48 | Head record timestamp |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that the bus inputs are synchronous to `clk`. They also assume that address, data and write enables are already steady at the edge where the chip-select rise is seen, so each rise stands for exactly one complete cycle. The stimulus changes every input only on the falling clock edge. It holds address, data and enables unchanged from the cycle in which the chip-select drops until after its rise has been sampled, and it pulses the clear and pop inputs for one full clock each.

// File: rtl/bus_cycle_logger.sv
module bus_cycle_logger #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int WEW = 2,
  parameter int SIDW = 8,
  parameter int TSW = 48,
  parameter int DEPTH = 8,
  parameter int OFFW = 4,
  parameter int FLOW_BIT = 30,
  parameter logic [AW-1:0] LOG_BASE = 32'hFF00_0000,
  parameter logic [OFFW-1:0] OFF_KF = 4'h0,
  parameter logic [OFFW-1:0] OFF_UF = 4'h4,
  parameter logic [OFFW-1:0] OFF_SID = 4'h8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   data_i,
  input  logic [WEW-1:0]  wen_n_i,
  input  logic            pop_i,
  input  logic            ovf_clr_i,
  output logic            rec_valid_o,
  output logic [2:0]      rec_type_o,
  output logic [AW-1:0]   rec_addr_o,
  output logic [DW-1:0]   rec_data_o,
  output logic [SIDW-1:0] rec_sid_o,
  output logic [TSW-1:0]  rec_ts_o,
  output logic            ovf_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] FULL_OCC = (PW+1)'(DEPTH);

  localparam logic [2:0] K_FETCH = 3'd0;
  localparam logic [2:0] K_FLOW  = 3'd1;
  localparam logic [2:0] K_KF    = 3'd2;
  localparam logic [2:0] K_UF    = 3'd3;
  localparam logic [2:0] K_SPACE = 3'd4;
  localparam logic [2:0] K_WRITE = 3'd5;

  logic            cs_q;
  logic [TSW-1:0]  ts_q;
  logic [SIDW-1:0] sid_q;
  logic [PW:0]     wp_q, rp_q;

  logic [2:0]      typ_m  [DEPTH];
  logic [AW-1:0]   addr_m [DEPTH];
  logic [DW-1:0]   data_m [DEPTH];
  logic [SIDW-1:0] sid_m  [DEPTH];
  logic [TSW-1:0]  ts_m   [DEPTH];

  wire rise  = cs_i & ~cs_q;
  wire [PW:0] occ = wp_q - rp_q;
  wire full  = (occ == FULL_OCC);
  wire empty = (occ == '0);
  wire push  = rise & ~full;
  wire pop   = pop_i & ~empty;

  wire is_read  = &wen_n_i;
  wire all_wr   = ~|wen_n_i;
  wire in_win   = addr_i[AW-1:OFFW] == LOG_BASE[AW-1:OFFW];
  wire [OFFW-1:0] off = addr_i[OFFW-1:0];

  logic [2:0]      kind;
  logic [SIDW-1:0] rec_sid;

  always_comb begin
    if (is_read)                          kind = K_FETCH;
    else if (all_wr && !addr_i[FLOW_BIT]) kind = K_FLOW;
    else if (in_win && off == OFF_KF)     kind = K_KF;
    else if (in_win && off == OFF_UF)     kind = K_UF;
    else if (in_win && off == OFF_SID)    kind = K_SPACE;
    else                                  kind = K_WRITE;
  end

  always_comb begin
    case (kind)
      K_KF, K_UF: rec_sid = sid_q;
      K_SPACE:    rec_sid = data_i[SIDW-1:0];
      default:    rec_sid = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q  <= 1'b1;
      ts_q  <= '0;
      sid_q <= '0;
      wp_q  <= '0;
      rp_q  <= '0;
      ovf_o <= 1'b0;
    end else begin
      cs_q <= cs_i;
      ts_q <= ts_q + {{(TSW-1){1'b0}}, 1'b1};
      if (rise && kind == K_SPACE) sid_q <= data_i[SIDW-1:0];
      if (push) wp_q <= wp_q + 1'b1;
      if (pop)  rp_q <= rp_q + 1'b1;
      if (rise && full) ovf_o <= 1'b1;
      else if (ovf_clr_i) ovf_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      typ_m[wp_q[PW-1:0]]  <= kind;
      addr_m[wp_q[PW-1:0]] <= addr_i;
      data_m[wp_q[PW-1:0]] <= data_i;
      sid_m[wp_q[PW-1:0]]  <= rec_sid;
      ts_m[wp_q[PW-1:0]]   <= ts_q;
    end
  end

  assign rec_valid_o = ~empty;
  assign rec_type_o  = typ_m[rp_q[PW-1:0]];
  assign rec_addr_o  = addr_m[rp_q[PW-1:0]];
  assign rec_data_o  = data_m[rp_q[PW-1:0]];
  assign rec_sid_o   = sid_m[rp_q[PW-1:0]];
  assign rec_ts_o    = ts_m[rp_q[PW-1:0]];

  // R9
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && full) |=> ovf_o);

  // R10
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ovf_clr_i) |=> ovf_o);

  // R10
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr_i && !rise) |=> !ovf_o);

  // R6
  sid_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable(sid_q));

  // R8
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= FULL_OCC);

  // R11
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !rise) |=> !rec_valid_o);

  // R1
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q && !pop && !ovf_clr_i) |=> $stable(wp_q));

endmodule

// File: tb/bus_cycle_logger_tb_top.sv
module bus_cycle_logger_tb_top;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_i = 1'b1;
  logic [31:0] addr_i = '0;
  logic [31:0] data_i = '0;
  logic [1:0]  wen_n_i = 2'b11;
  logic        pop_i = 1'b0;
  logic        ovf_clr_i = 1'b0;
  logic        rec_valid_o;
  logic [2:0]  rec_type_o;
  logic [31:0] rec_addr_o;
  logic [31:0] rec_data_o;
  logic [7:0]  rec_sid_o;
  logic [47:0] rec_ts_o;
  logic        ovf_o;

  bus_cycle_logger dut_i (
    .clk(clk), .rst_n(rst_n), .cs_i(cs_i), .addr_i(addr_i), .data_i(data_i),
    .wen_n_i(wen_n_i), .pop_i(pop_i), .ovf_clr_i(ovf_clr_i),
    .rec_valid_o(rec_valid_o), .rec_type_o(rec_type_o), .rec_addr_o(rec_addr_o),
    .rec_data_o(rec_data_o), .rec_sid_o(rec_sid_o), .rec_ts_o(rec_ts_o),
    .ovf_o(ovf_o)
  );

  always #10 clk = ~clk;

  logic [47:0] tb_cnt;
  always @(posedge clk) begin
    if (!rst_n) tb_cnt <= '0;
    else tb_cnt <= tb_cnt + 48'd1;
  end

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  logic [2:0]  m_type [0:255];
  logic [31:0] m_addr [0:255];
  logic [31:0] m_data [0:255];
  logic [7:0]  m_sidr [0:255];
  logic [47:0] m_ts   [0:255];
  int m_head = 0;
  int m_tail = 0;
  logic [7:0] m_sid = '0;
  logic m_ovf = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_cyc(input logic [31:0] a, input logic [31:0] d,
                         input logic [1:0] we, input logic [2:0] t, input bit clr);
    logic [7:0] s;
    @(negedge clk);
    cs_i = 1'b0; addr_i = a; data_i = d; wen_n_i = we;
    @(negedge clk);
    cs_i = 1'b1; ovf_clr_i = clr;
    if (t == 3'd4) begin s = d[7:0]; m_sid = d[7:0]; end
    else if (t == 3'd2 || t == 3'd3) s = m_sid;
    else s = 8'h00;
    if (m_tail - m_head < DEPTH) begin
      m_type[m_tail[7:0]] = t; m_addr[m_tail[7:0]] = a; m_data[m_tail[7:0]] = d;
      m_sidr[m_tail[7:0]] = s; m_ts[m_tail[7:0]] = tb_cnt;
      m_tail++;
    end else m_ovf = 1'b1;
    if (clr && !(m_tail - m_head == DEPTH && m_ovf)) m_ovf = m_ovf;
    @(negedge clk);
    ovf_clr_i = 1'b0; wen_n_i = 2'b11;
  endtask

  task automatic drain(input string req);
    while (m_head < m_tail) begin
      check({req, " valid"}, 64'(rec_valid_o), 64'd1);
      check({req, " type"}, 64'(rec_type_o), 64'(m_type[m_head[7:0]]));
      check({req, " addr"}, 64'(rec_addr_o), 64'(m_addr[m_head[7:0]]));
      check({req, " data"}, 64'(rec_data_o), 64'(m_data[m_head[7:0]]));
      check({req, " sid"}, 64'(rec_sid_o), 64'(m_sidr[m_head[7:0]]));
      check({req, " ts"}, 64'(rec_ts_o), 64'(m_ts[m_head[7:0]]));
      pop_i = 1'b1;
      @(negedge clk);
      pop_i = 1'b0;
      m_head++;
    end
    check({req, " empty after drain"}, 64'(rec_valid_o), 64'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cs_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 no record after reset with cs high", 64'(rec_valid_o), 64'd0);
    check("R10 overflow clear after reset", 64'(ovf_o), 64'd0);
  endtask

  task automatic t_fetch;
    bus_cyc(32'h0000_0100, 32'hDEAD_BEEF, 2'b11, 3'd0, 0);
    bus_cyc(32'hFF00_0000, 32'h1111_2222, 2'b11, 3'd0, 0);
    drain("R2 R3 fetch");
  endtask

  task automatic t_flow;
    bus_cyc(32'h8000_0010, 32'h0040_1234, 2'b00, 3'd1, 0);
    bus_cyc(32'h0000_0008, 32'h0040_2000, 2'b00, 3'd1, 0);
    bus_cyc(32'h8000_0010, 32'h0000_0077, 2'b10, 3'd5, 0);
    bus_cyc(32'h8000_0010, 32'h0000_0078, 2'b01, 3'd5, 0);
    drain("R4 flow");
  endtask

  task automatic t_log;
    bus_cyc(32'hFF00_0000, 32'h0010_0000, 2'b00, 3'd2, 0);
    bus_cyc(32'hFF00_0008, 32'h0000_005A, 2'b00, 3'd4, 0);
    bus_cyc(32'hFF00_0000, 32'h0010_0040, 2'b00, 3'd2, 0);
    bus_cyc(32'hFF00_0004, 32'h1000_0080, 2'b00, 3'd3, 0);
    bus_cyc(32'hFF00_000C, 32'h0000_0099, 2'b00, 3'd5, 0);
    bus_cyc(32'hFF00_0010, 32'h0000_0098, 2'b00, 3'd5, 0);
    bus_cyc(32'hFF00_0008, 32'hABCD_0033, 2'b00, 3'd4, 0);
    bus_cyc(32'hFF00_0004, 32'h1000_00C0, 2'b00, 3'd3, 0);
    drain("R5 R6 log offsets and space id");
  endtask

  task automatic t_timing;
    bus_cyc(32'h0000_0200, 32'h0000_0001, 2'b11, 3'd0, 0);
    repeat (7) @(negedge clk);
    bus_cyc(32'h0000_0204, 32'h0000_0002, 2'b11, 3'd0, 0);
    repeat (5) @(negedge clk);
    check("R1 held cs gives no extra record", 64'(m_tail - m_head), 64'd2);
    drain("R1 R7 timestamp");
  endtask

  task automatic t_full;
    for (int i = 0; i < DEPTH + 2; i++)
      bus_cyc(32'h0000_1000 + 32'(i * 4), 32'h5000_0000 + 32'(i), 2'b11, 3'd0, 0);
    check("R9 overflow set on drop", 64'(ovf_o), 64'd1);
    drain("R8 R9 full buffer order");
    check("R10 overflow held after drain", 64'(ovf_o), 64'd1);
    ovf_clr_i = 1'b1;
    @(negedge clk);
    ovf_clr_i = 1'b0;
    check("R10 overflow cleared", 64'(ovf_o), 64'd0);
    for (int i = 0; i < DEPTH; i++)
      bus_cyc(32'h0000_2000 + 32'(i * 4), 32'h6000_0000 + 32'(i), 2'b11, 3'd0, 0);
    check("R9 no overflow at exactly full", 64'(ovf_o), 64'd0);
    bus_cyc(32'h0000_3000, 32'h7000_0000, 2'b11, 3'd0, 1);
    check("R10 drop wins over clear", 64'(ovf_o), 64'd1);
    drain("R8 refill");
    ovf_clr_i = 1'b1;
    @(negedge clk);
    ovf_clr_i = 1'b0;
    check("R10 overflow cleared again", 64'(ovf_o), 64'd0);
  endtask

  task automatic t_pop_empty;
    pop_i = 1'b1;
    repeat (2) @(negedge clk);
    pop_i = 1'b0;
    check("R11 empty after pop on empty", 64'(rec_valid_o), 64'd0);
    bus_cyc(32'h0000_4000, 32'h0BAD_F00D, 2'b11, 3'd0, 0);
    drain("R11 record intact after empty pop");
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fetch();
    t_flow();
    t_log();
    t_timing();
    t_full();
    t_pop_empty();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule